// File: doc/BRIEF.md
# Two-Speed Systolic FIR Convolution Array

This block computes a one-dimensional FIR convolution with a linear chain of identical cells, one filter tap per cell. For a kernel w1..wK and a sample stream x1, x2, ... it produces y_i = w1·x_i + w2·x_(i+1) + ... + wK·x_(i+K-1). Samples and partial sums both travel left to right. A partial sum enters the leftmost cell as zero each time a sample is accepted. Each cell it crosses adds its own weight times the sample it finds there. The partial-sum path holds each value for more register stages per cell than the sample path does. Samples therefore overtake partial sums by exactly one position per cell, and each partial sum meets the K consecutive samples it needs.

The number of partial-sum stages in each cell follows the multiply-add latency MAC_LAT. It is two stages for a single-cycle multiply-add and MAC_LAT stages otherwise. The sample path always has one stage fewer. A two-state mode controller sets when weights may change. In the load state, weights are written one tap at a time and samples are ignored. A start pulse clears the in-flight pipeline and enters the run state. There, every sample flagged valid moves the whole array by one step, and weight writes are ignored. A stop pulse returns the block to the load state. Only fully accumulated partial sums leave with the valid flag raised.

Top module: `sys_fir_top`

## Requirements
- R1: After reset the block is in the load state, y_valid and y_data are 0, and every weight is 0. A run without any weight writes therefore produces only zero results.
- R2: In the load state, a cycle with wt_we high writes wt_data into the tap selected by wt_idx. Index 0 is w1, the weight applied to the earliest sample of each output window, and index K-1 is wK. Indices at or above K write nothing.
- R3: A go pulse in the load state enters the run state and discards every partial sum and sample still in the chain. After that, outputs depend only on samples accepted since that go.
- R4: In the run state each cycle with x_valid high accepts x_data. The n-th valid output after a go equals the exact signed sum of w_j·x_(n+j-1) for j = 1..K, where x_m is the m-th sample accepted since that go.
- R5: The n-th valid output appears, with y_valid high, in the cycle after the acceptance of sample n + K·S - 1. S is 2 when MAC_LAT is 1 and MAC_LAT otherwise. No valid output appears before K·S samples have been accepted.
- R6: Cycles in the run state with x_valid low move no data, raise no y_valid, and leave the values of later outputs unchanged. y_valid is high only in a cycle that directly follows an accepted sample.
- R7: Weight writes in the run state have no effect on any weight or output.
- R8: A stop pulse in the run state returns the block to the load state. Samples presented in the load state are not accepted and produce no y_valid.
- R9: Results are exact two's-complement sums on 40 bits with 16-bit signed samples and weights. For default parameters, this includes the extreme case in which every product is (-32768)·(-32768).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_we | input | 1 | Weight write strobe (load state only) |
| wt_idx | input | max(1, clog2(TAPS)) | Tap index of the weight write |
| wt_data | input | WW | Signed weight value |
| go | input | 1 | Leave the load state, clear the chain, start running |
| stop | input | 1 | Leave the run state |
| x_valid | input | 1 | Sample strobe; advances the array in the run state |
| x_data | input | XW | Signed sample |
| y_valid | output | 1 | Fully accumulated result present on y_data |
| y_data | output | AW | Signed convolution result |

## Verification
The bench builds two copies of the block side by side from the same stimulus. One has four taps with a three-cycle multiply-add, so each partial sum spends three cycles per cell and the first result appears after twelve samples. The other has three taps with a single-cycle multiply-add, which uses the two-stage partial-sum path and fills after six samples. Together they exercise both ways of choosing the per-cell stage count. They also cover a write to an index beyond the kernel, which the smaller copy must discard. Irregular gaps in the sample strobe, restarts with partial sums still in flight, and worst-case negative operands show that output position and value depend only on accepted samples and on the weights loaded before the run.

// File: rtl/sys_fir_pkg.sv
package sys_fir_pkg;

    typedef enum logic {
        S_LOAD = 1'b0,
        S_RUN  = 1'b1
    } run_state_e;

    // Partial-sum register stages per cell for a given multiply-add latency.
    function automatic int sum_stages(input int mac_lat);
        return (mac_lat < 2) ? 2 : mac_lat;
    endfunction

endpackage

// File: rtl/sys_fir_ctrl.sv
module sys_fir_ctrl
    import sys_fir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       stop,
    input  logic       x_valid,
    input  logic       wt_we,
    output run_state_e state_q,
    output logic       adv,
    output logic       clr,
    output logic       wt_en
);

    run_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_LOAD;
        else        state_q <= state_d;
    end

    // Transitions: LOAD_TO_RUN on go, RUN_TO_LOAD on stop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_LOAD:  if (go)   state_d = S_RUN;
            S_RUN:   if (stop) state_d = S_LOAD;
            default: state_d = S_LOAD;
        endcase
    end

    always_comb begin
        adv   = 1'b0;
        clr   = 1'b0;
        wt_en = 1'b0;
        unique case (state_q)
            S_LOAD: begin
                wt_en = wt_we;
                clr   = go;
            end
            S_RUN: begin
                adv = x_valid;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sys_fir_mac.sv
module sys_fir_mac #(
    parameter int XW = 16,
    parameter int WW = 16,
    parameter int AW = 40
) (
    input  logic signed [XW-1:0] x,
    input  logic signed [WW-1:0] w,
    input  logic signed [AW-1:0] acc_in,
    output logic signed [AW-1:0] acc_out
);

    localparam int PW = XW + WW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;

    assign prod     = PW'(x) * PW'(w);
    assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
    assign acc_out  = acc_in + prod_ext;

endmodule

// File: rtl/sys_fir_cell.sv
module sys_fir_cell #(
    parameter int XW = 16,
    parameter int WW = 16,
    parameter int AW = 40,
    parameter int YD = 3,
    parameter int XD = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 clr,
    input  logic                 wt_load,
    input  logic signed [WW-1:0] wt_d,
    input  logic signed [XW-1:0] x_in,
    input  logic signed [AW-1:0] y_in,
    input  logic                 v_in,
    output logic signed [XW-1:0] x_out,
    output logic signed [AW-1:0] y_out,
    output logic                 v_out,
    output logic signed [WW-1:0] w_out
);

    logic signed [WW-1:0] w_q;
    logic signed [XW-1:0] xr [XD];
    logic signed [AW-1:0] yr [YD];
    logic                 vr [YD];
    logic signed [AW-1:0] mac_y;

    sys_fir_mac #(.XW(XW), .WW(WW), .AW(AW)) i_mac (
        .x      (x_in),
        .w      (w_q),
        .acc_in (y_in),
        .acc_out(mac_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       w_q <= '0;
        else if (wt_load) w_q <= wt_d;
    end

    // Sample path: XD stages, one fewer than the partial-sum path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < XD; k++) xr[k] <= '0;
        end else if (clr) begin
            for (int k = 0; k < XD; k++) xr[k] <= '0;
        end else if (adv) begin
            xr[0] <= x_in;
            for (int k = 1; k < XD; k++) xr[k] <= xr[k-1];
        end
    end

    // Partial-sum path: first stage takes the multiply-add result, the rest
    // carry it so that the value spends YD steps in this cell.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < YD; k++) begin
                yr[k] <= '0;
                vr[k] <= 1'b0;
            end
        end else if (clr) begin
            for (int k = 0; k < YD; k++) begin
                yr[k] <= '0;
                vr[k] <= 1'b0;
            end
        end else if (adv) begin
            yr[0] <= mac_y;
            vr[0] <= v_in;
            for (int k = 1; k < YD; k++) begin
                yr[k] <= yr[k-1];
                vr[k] <= vr[k-1];
            end
        end
    end

    assign x_out = xr[XD-1];
    assign y_out = yr[YD-1];
    assign v_out = vr[YD-1];
    assign w_out = w_q;

endmodule

// File: rtl/sys_fir_top.sv
module sys_fir_top
    import sys_fir_pkg::*;
#(
    parameter int TAPS    = 4,
    parameter int MAC_LAT = 3,
    parameter int XW      = 16,
    parameter int WW      = 16,
    parameter int AW      = 40,
    localparam int IW     = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wt_we,
    input  logic [IW-1:0] wt_idx,
    input  logic [WW-1:0] wt_data,
    input  logic          go,
    input  logic          stop,
    input  logic          x_valid,
    input  logic [XW-1:0] x_data,
    output logic          y_valid,
    output logic [AW-1:0] y_data
);

    localparam int YD = sum_stages(MAC_LAT);
    localparam int XD = YD - 1;

    run_state_e state_q;
    logic       adv;
    logic       clr;
    logic       wt_en;
    logic       adv_q;

    logic signed [XW-1:0] x_ch [TAPS+1];
    logic signed [AW-1:0] y_ch [TAPS+1];
    logic                 v_ch [TAPS+1];
    logic [TAPS*WW-1:0]   wt_vec;

    sys_fir_ctrl i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .stop   (stop),
        .x_valid(x_valid),
        .wt_we  (wt_we),
        .state_q(state_q),
        .adv    (adv),
        .clr    (clr),
        .wt_en  (wt_en)
    );

    assign x_ch[0] = x_data;
    assign y_ch[0] = '0;
    assign v_ch[0] = 1'b1;

    for (genvar j = 0; j < TAPS; j++) begin : g_cell
        logic signed [WW-1:0] w_j;
        logic                 load_j;

        assign load_j = wt_en && (wt_idx == IW'(j));

        sys_fir_cell #(
            .XW(XW), .WW(WW), .AW(AW), .YD(YD), .XD(XD)
        ) i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (adv),
            .clr    (clr),
            .wt_load(load_j),
            .wt_d   (wt_data),
            .x_in   (x_ch[j]),
            .y_in   (y_ch[j]),
            .v_in   (v_ch[j]),
            .x_out  (x_ch[j+1]),
            .y_out  (y_ch[j+1]),
            .v_out  (v_ch[j+1]),
            .w_out  (w_j)
        );

        assign wt_vec[j*WW +: WW] = w_j;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) adv_q <= 1'b0;
        else        adv_q <= adv;
    end

    assign y_valid = adv_q && v_ch[TAPS];
    assign y_data  = y_ch[TAPS];

endmodule

// File: rtl/sys_fir_chk.sv
module sys_fir_chk
    import sys_fir_pkg::*;
#(
    parameter int TAPS    = 4,
    parameter int MAC_LAT = 3,
    parameter int WW      = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stop,
    input logic               adv,
    input logic               clr,
    input run_state_e         state_q,
    input logic [TAPS*WW-1:0] wt_vec,
    input logic               y_valid
);

    localparam int FILL = TAPS * sum_stages(MAC_LAT);
    localparam int CW   = $clog2(FILL + 1) + 1;

    logic [CW-1:0] fill_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          fill_cnt <= '0;
        else if (clr)                        fill_cnt <= '0;
        else if (adv && fill_cnt < CW'(FILL)) fill_cnt <= fill_cnt + 1'b1;
    end

    p_fill_before_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (fill_cnt >= CW'(FILL)));

    p_output_follows_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> $past(adv));

    p_weights_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |=> $stable(wt_vec));

    p_go_enters_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == S_RUN) && (fill_cnt == '0));

    p_stop_enters_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) && stop |=> (state_q == S_LOAD));

    p_load_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD) |=> !y_valid);

endmodule

bind sys_fir_top sys_fir_chk #(
    .TAPS(TAPS), .MAC_LAT(MAC_LAT), .WW(WW)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .stop   (stop),
    .adv    (adv),
    .clr    (clr),
    .state_q(state_q),
    .wt_vec (wt_vec),
    .y_valid(y_valid)
);

// File: tb/test_sys_fir_top.sv
module test_sys_fir_top;

    localparam int FILL_A = 12;   // 4 taps, 3 stages per cell
    localparam int FILL_B = 6;    // 3 taps, 2 stages per cell
    localparam int MAXN   = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wt_we = 1'b0;
    logic [1:0]  wt_idx = '0;
    logic [15:0] wt_data = '0;
    logic        go = 1'b0;
    logic        stop = 1'b0;
    logic        x_valid = 1'b0;
    logic [15:0] x_data = '0;
    logic        y_valid_a, y_valid_b;
    logic [39:0] y_data_a, y_data_b;

    always #2 clk = ~clk;

    sys_fir_top #(.TAPS(4), .MAC_LAT(3)) i_sys_fir_top (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_idx(wt_idx),
        .wt_data(wt_data), .go(go), .stop(stop), .x_valid(x_valid),
        .x_data(x_data), .y_valid(y_valid_a), .y_data(y_data_a)
    );

    sys_fir_top #(.TAPS(3), .MAC_LAT(1)) i_sys_fir_top_b (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_idx(wt_idx),
        .wt_data(wt_data), .go(go), .stop(stop), .x_valid(x_valid),
        .x_data(x_data), .y_valid(y_valid_b), .y_data(y_data_b)
    );

    int      n_checks = 0;
    int      n_fail   = 0;
    bit      finished = 1'b0;
    bit      running  = 1'b0;
    int      acc;
    int      na, nb;
    longint  cap_a [MAXN];
    longint  cap_b [MAXN];
    int      at_a  [MAXN];
    int      at_b  [MAXN];
    logic signed [15:0] xs [MAXN];
    logic signed [15:0] wk [4];
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic longint ref_y(int i, int k);
        longint s = 0;
        for (int j = 0; j < k; j++) s += longint'(wk[j]) * longint'(xs[i+j]);
        return s;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        if (running && x_valid) acc++;
        if (!running && go) running = 1'b1;
        else if (running && stop) running = 1'b0;
        @(negedge clk);
        if (y_valid_a && na < MAXN) begin
            cap_a[na] = longint'($signed(y_data_a));
            at_a[na]  = acc;
            na++;
        end
        if (y_valid_b && nb < MAXN) begin
            cap_b[nb] = longint'($signed(y_data_b));
            at_b[nb]  = acc;
            nb++;
        end
    endtask

    task automatic load_weights();
        for (int j = 0; j < 4; j++) begin
            wt_we = 1'b1; wt_idx = 2'(j); wt_data = wk[j];
            cyc();
        end
        wt_we = 1'b0;
    endtask

    task automatic start_run();
        na = 0; nb = 0; acc = 0;
        go = 1'b1;
        cyc();
        go = 1'b0;
    endtask

    task automatic stop_run();
        stop = 1'b1;
        cyc();
        stop = 1'b0;
    endtask

    task automatic feed(int n, bit gaps, bit wr_noise);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                int g = int'(rnd() % 4);
                for (int k = 0; k < g; k++) begin
                    x_valid = 1'b0;
                    cyc();
                end
            end
            x_valid = 1'b1;
            x_data  = xs[i];
            if (wr_noise) begin
                wt_we = 1'b1; wt_idx = 2'(i % 4); wt_data = 16'(rnd());
            end
            cyc();
        end
        x_valid = 1'b0;
        wt_we   = 1'b0;
    endtask

    task automatic verify(int n, string tag);
        check(na == n - FILL_A + 1, {tag, " count A"}, na, n - FILL_A + 1);
        check(nb == n - FILL_B + 1, {tag, " count B"}, nb, n - FILL_B + 1);
        for (int i = 0; i < na && i <= n - FILL_A; i++) begin
            check(cap_a[i] == ref_y(i, 4), {tag, " value A"}, cap_a[i], ref_y(i, 4));
            check(at_a[i] == i + FILL_A, "R5 position A", at_a[i], i + FILL_A);
        end
        for (int i = 0; i < nb && i <= n - FILL_B; i++) begin
            check(cap_b[i] == ref_y(i, 3), {tag, " value B"}, cap_b[i], ref_y(i, 3));
            check(at_b[i] == i + FILL_B, "R5 position B", at_b[i], i + FILL_B);
        end
    endtask

    task automatic rand_kernel();
        for (int j = 0; j < 4; j++) wk[j] = 16'(rnd());
    endtask

    task automatic rand_samples(int n);
        for (int i = 0; i < n; i++) xs[i] = 16'(rnd());
    endtask

    // R1: reset state, and zero weights after reset
    task automatic t_reset();
        check(y_valid_a == 1'b0, "R1 y_valid A", y_valid_a, 0);
        check(y_data_a == '0, "R1 y_data A", y_data_a, 0);
        check(y_valid_b == 1'b0, "R1 y_valid B", y_valid_b, 0);
        check(y_data_b == '0, "R1 y_data B", y_data_b, 0);
        for (int j = 0; j < 4; j++) wk[j] = '0;
        rand_samples(24);
        start_run();
        feed(24, 1'b0, 1'b0);
        verify(24, "R1");
        stop_run();
    endtask

    // R2 and R4: ramp kernel, ramp samples
    task automatic t_basic();
        for (int j = 0; j < 4; j++) wk[j] = 16'(j + 1);
        for (int i = 0; i < 40; i++) xs[i] = 16'(i + 1);
        load_weights();
        start_run();
        feed(40, 1'b0, 1'b0);
        check(cap_a[0] == 30, "R2 first output A", cap_a[0], 30);
        check(cap_b[0] == 14, "R2 first output B", cap_b[0], 14);
        verify(40, "R4");
        stop_run();
    endtask

    // R6: irregular sample strobe
    task automatic t_stall();
        rand_kernel();
        rand_samples(50);
        load_weights();
        start_run();
        feed(50, 1'b1, 1'b0);
        verify(50, "R6");
        stop_run();
    endtask

    // R9: extreme operands
    task automatic t_extreme();
        for (int j = 0; j < 4; j++) wk[j] = -16'sd32768;
        for (int i = 0; i < 20; i++) xs[i] = -16'sd32768;
        load_weights();
        start_run();
        feed(20, 1'b0, 1'b0);
        check(cap_a[0] == 64'sd4294967296, "R9 max A", cap_a[0], 64'sd4294967296);
        verify(20, "R9");
        stop_run();
        for (int j = 0; j < 4; j++) wk[j] = 16'sd32767;
        for (int i = 0; i < 20; i++) xs[i] = -16'sd32768;
        load_weights();
        start_run();
        feed(20, 1'b0, 1'b0);
        verify(20, "R9");
        stop_run();
    endtask

    // R7: weight writes during the run are discarded
    task automatic t_run_write();
        rand_kernel();
        rand_samples(36);
        load_weights();
        start_run();
        feed(36, 1'b0, 1'b1);
        verify(36, "R7");
    endtask

    // R8: after stop, samples are not accepted
    task automatic t_stop();
        int na0, nb0;
        stop_run();
        na0 = na; nb0 = nb;
        for (int i = 0; i < 20; i++) xs[i] = 16'(i * 7);
        feed(20, 1'b0, 1'b0);
        check(na == na0, "R8 no output A", na, na0);
        check(nb == nb0, "R8 no output B", nb, nb0);
    endtask

    // R3: restart with partial sums in flight
    task automatic t_restart();
        rand_kernel();
        rand_samples(10);
        load_weights();
        start_run();
        feed(10, 1'b0, 1'b0);
        stop_run();
        rand_kernel();
        rand_samples(30);
        load_weights();
        start_run();
        feed(30, 1'b0, 1'b0);
        verify(30, "R3");
        stop_run();
    endtask

    // R4: random kernels and random samples
    task automatic t_random();
        for (int r = 0; r < 3; r++) begin
            rand_kernel();
            rand_samples(60);
            load_weights();
            start_run();
            feed(60, r[0], 1'b0);
            verify(60, "R4");
            stop_run();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stall();
        t_extreme();
        t_run_write();
        t_stop();
        t_restart();
        t_random();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule